// File: doc/BRIEF.md
# Backplane Bus Cycle Sequencer

This block is the cycle engine of a permanent bus master on a 100-pin parallel backplane. A core hands it one transfer at a time over a valid/ready handshake: a memory read, a memory write, an I/O input, an I/O output, an opcode fetch or an interrupt acknowledge. The sequencer turns each request into a framed bus cycle. It drives the address and the status lines for the cycle type, a one-clock start-of-cycle pulse with its status-valid qualifier, and then the read or write strobe.

While the read or write strobe is active, the ready line from the addressed slave is sampled on every clock. A low level adds wait states. On the clock where ready is seen high, read data is captured and returned to the core as a one-clock response. The block also decodes the memory-write strobe from the write strobe and the output status, so that memory boards see writes from this master and never see I/O writes.

Each cycle passes through four phases. The first is a sync phase of one clock. The second is the strobe phase, which repeats while ready is low. The third is a release phase of one clock. The block then returns to idle, where it can take the next request.

Top module: `bp_cycle_seq`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `psync` is 0, `pdbin` is 0, `mwrt` is 0, `rsp_valid` is 0, `pstval_n` and `pwr_n` are 1, all active-high status lines are 0 and `st_wo_n` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the clock that follows, `psync` is 1 and `pstval_n` is 0. Both last exactly one clock, and `pstval_n` is never low unless `psync` is high.
- R3: Request kinds are encoded as 0 memory read, 1 memory write, 2 I/O input, 3 I/O output, 4 opcode fetch, 5 interrupt acknowledge; codes 6 and 7 act as memory read. The status is held from the sync phase through the release phase. The status lines are:
  - memory read: `st_memr`.
  - opcode fetch: `st_memr` and `st_m1`.
  - I/O input: `st_inp`.
  - I/O output: `st_out` together with `st_wo_n` low.
  - memory write: `st_wo_n` low.
  - interrupt acknowledge: `st_inta`.
- R4: `pdbin` is 1 throughout the strobe phase for memory read, I/O input, opcode fetch and interrupt acknowledge cycles. It is 0 at all other times and never overlaps the write strobe.
- R5: `pwr_n` is 0 throughout the strobe phase for memory write and I/O output cycles, with `bus_dout` equal to the request's write data. It is 1 at all other times.
- R6: Each clock edge of the strobe phase at which `bus_rdy` is 0 extends that phase by one clock. The release phase follows the first edge that sees `bus_rdy` high.
- R7: For reading kinds, `bus_din` is captured at the edge that ends the strobe phase. It is returned on `rsp_data`, with `rsp_valid` high for exactly the one clock of the release phase. Values present during wait states are not returned. An interrupt acknowledge returns its vector byte this way.
- R8: `mwrt` is 1 exactly when the write strobe is active and `st_out` is 0. It is therefore high during the strobe phase of memory writes and never during I/O output.
- R9: `bus_addr` holds the request address from the sync phase through the release phase.
- R10: `req_ready` is 0 from the sync phase through the release phase. A request presented in that span is ignored: `bus_addr` and the status lines keep the current cycle's values. The request is taken only at the first idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_kind | input | 3 | Cycle kind code (see R3) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data returned (one clock) |
| rsp_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Backplane address |
| bus_dout | output | DATA_W | Backplane data out |
| bus_din | input | DATA_W | Backplane data in |
| bus_rdy | input | 1 | Slave ready, low inserts waits |
| psync | output | 1 | Start-of-cycle pulse |
| pstval_n | output | 1 | Status-valid strobe, active low |
| pdbin | output | 1 | Read strobe |
| pwr_n | output | 1 | Write strobe, active low |
| mwrt | output | 1 | Memory-write strobe |
| st_memr | output | 1 | Memory read status |
| st_m1 | output | 1 | Opcode fetch status |
| st_inp | output | 1 | I/O input status |
| st_out | output | 1 | I/O output status |
| st_wo_n | output | 1 | Write-out status, active low |
| st_inta | output | 1 | Interrupt acknowledge status |

## Verification
The release of a wait state and the capture of read data happen on the same clock edge. The returned byte must therefore be the one on `bus_din` when `bus_rdy` first reads high, not any earlier one. To provoke this, the bench drives the inverse of the expected byte during every wait clock and switches to the real byte only in the clock where it raises ready. Any capture taken one edge early or late returns the decoy. A second collision is a request held during the release phase: it must not alter the running cycle, and must start a new cycle exactly one clock after idle is reached.

// File: rtl/bp_seq_pkg.sv
package bp_seq_pkg;

  typedef enum logic [2:0] {
    K_MEMRD = 3'd0,
    K_MEMWR = 3'd1,
    K_IOIN  = 3'd2,
    K_IOOUT = 3'd3,
    K_FETCH = 3'd4,
    K_INTA  = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } phase_e;

  typedef struct packed {
    logic memr;
    logic m1;
    logic inp;
    logic out;
    logic wo;
    logic inta;
  } status_t;

  // Status pattern per request kind; unknown codes act as memory read.
  function automatic status_t status_of(input logic [2:0] k);
    status_t s;
    s = '0;
    case (k)
      K_MEMWR: s.wo = 1'b1;
      K_IOIN:  s.inp = 1'b1;
      K_IOOUT: begin s.out = 1'b1; s.wo = 1'b1; end
      K_FETCH: begin s.memr = 1'b1; s.m1 = 1'b1; end
      K_INTA:  s.inta = 1'b1;
      default: s.memr = 1'b1;
    endcase
    return s;
  endfunction

  function automatic logic status_reads(input status_t s);
    return s.memr | s.inp | s.inta;
  endfunction

  function automatic logic mem_write_strobe(input logic wr_active, input logic out_status);
    return wr_active & ~out_status;
  endfunction

endpackage

// File: rtl/bp_phase_fsm.sv
module bp_phase_fsm
  import bp_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy,
  output logic ph_idle,
  output logic ph_t1,
  output logic ph_t2,
  output logic ph_t3
);

  phase_e ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) ph_q <= PH_T1;
        PH_T1:   ph_q <= PH_T2;
        PH_T2:   if (rdy) ph_q <= PH_T3;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ph_idle = (ph_q == PH_IDLE);
  assign ph_t1   = (ph_q == PH_T1);
  assign ph_t2   = (ph_q == PH_T2);
  assign ph_t3   = (ph_q == PH_T3);

endmodule

// File: rtl/bp_status_reg.sv
module bp_status_reg
  import bp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       clear,
  input  logic [2:0] kind,
  output status_t    st
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (load) begin
      st <= status_of(kind);
    end else if (clear) begin
      st <= '0;
    end
  end

endmodule

// File: rtl/bp_data_path.sv
module bp_data_path #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_dout <= '0;
      rd_data  <= '0;
    end else begin
      if (load) begin
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
      end
      if (capture) rd_data <= bus_din;
    end
  end

endmodule

// File: rtl/bp_cycle_seq.sv
module bp_cycle_seq
  import bp_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy,
  output logic              psync,
  output logic              pstval_n,
  output logic              pdbin,
  output logic              pwr_n,
  output logic              mwrt,
  output logic              st_memr,
  output logic              st_m1,
  output logic              st_inp,
  output logic              st_out,
  output logic              st_wo_n,
  output logic              st_inta
);

  // Named internal events, visible to the bound checker.
  logic    ph_idle, ph_t1, ph_t2, ph_t3;
  logic    accept, capture, in_cycle, rd_cyc, wr_strobe;
  logic    rsp_q;
  status_t st;

  assign accept   = req_valid & ph_idle;
  assign in_cycle = ~ph_idle;

  bp_phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .rdy     (bus_rdy),
    .ph_idle (ph_idle),
    .ph_t1   (ph_t1),
    .ph_t2   (ph_t2),
    .ph_t3   (ph_t3)
  );

  bp_status_reg u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .clear (ph_t3),
    .kind  (req_kind),
    .st    (st)
  );

  assign rd_cyc    = status_reads(st);
  assign capture   = ph_t2 & bus_rdy & rd_cyc;
  assign wr_strobe = ph_t2 & st.wo;

  bp_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rd_data   (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= capture;
  end

  assign rsp_valid = rsp_q;
  assign req_ready = ph_idle;
  assign psync     = ph_t1;
  assign pstval_n  = ~ph_t1;
  assign pdbin     = ph_t2 & rd_cyc;
  assign pwr_n     = ~wr_strobe;
  assign mwrt      = mem_write_strobe(wr_strobe, st.out);
  assign st_memr   = st.memr;
  assign st_m1     = st.m1;
  assign st_inp    = st.inp;
  assign st_out    = st.out;
  assign st_wo_n   = ~st.wo;
  assign st_inta   = st.inta;

endmodule

// File: rtl/bp_cycle_chk.sv
module bp_cycle_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psync,
  input logic              pstval_n,
  input logic              pdbin,
  input logic              pwr_n,
  input logic              mwrt,
  input logic              st_out,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_rdy,
  input logic              ph_t2,
  input logic              in_cycle,
  input logic [ADDR_W-1:0] bus_addr
);

  a_r2_sync_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    psync |=> !psync);

  a_r2_stval_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !pstval_n |-> psync);

  a_r4_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(pdbin && !pwr_n));

  a_r6_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_t2 && !bus_rdy) |=> ph_t2);

  a_r7_rsp_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_mwrt_no_io: assert property (@(posedge clk) disable iff (!rst_n)
    mwrt |-> (!pwr_n && !st_out));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && !psync) |-> $stable(bus_addr));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_cycle |-> !req_ready);

endmodule

bind bp_cycle_seq bp_cycle_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .psync     (psync),
  .pstval_n  (pstval_n),
  .pdbin     (pdbin),
  .pwr_n     (pwr_n),
  .mwrt      (mwrt),
  .st_out    (st_out),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_rdy   (bus_rdy),
  .ph_t2     (ph_t2),
  .in_cycle  (in_cycle),
  .bus_addr  (bus_addr)
);

// File: tb/sim_bp_cycle_seq.sv
`timescale 1ns/1ps
module sim_bp_cycle_seq;

  localparam int AW = 24;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din = '0;
  logic          bus_rdy = 1'b1;
  logic psync, pstval_n, pdbin, pwr_n, mwrt;
  logic st_memr, st_m1, st_inp, st_out, st_wo_n, st_inta;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bp_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_rdy(bus_rdy),
    .psync(psync), .pstval_n(pstval_n), .pdbin(pdbin), .pwr_n(pwr_n),
    .mwrt(mwrt), .st_memr(st_memr), .st_m1(st_m1), .st_inp(st_inp),
    .st_out(st_out), .st_wo_n(st_wo_n), .st_inta(st_inta)
  );

  // {kind, addr, wdata, din, waits, status{memr,m1,inp,out,wo,inta}}
  localparam int VW = 3 + AW + DW + DW + 4 + 6;
  localparam logic [VW-1:0] VEC [8] = '{
    {3'd0, 24'h001234, 8'h00, 8'hA5, 4'd0, 6'b100000},
    {3'd1, 24'h00BEEF, 8'h3C, 8'h00, 4'd0, 6'b000010},
    {3'd2, 24'h000042, 8'h00, 8'h77, 4'd2, 6'b001000},
    {3'd3, 24'h000081, 8'hC3, 8'h00, 4'd1, 6'b000110},
    {3'd4, 24'hFFFFFF, 8'h00, 8'h0E, 4'd3, 6'b110000},
    {3'd5, 24'h000000, 8'h00, 8'hFF, 4'd0, 6'b000001},
    {3'd1, 24'h800000, 8'h5A, 8'h00, 4'd2, 6'b000010},
    {3'd7, 24'h123456, 8'h00, 8'h11, 4'd1, 6'b100000}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] st_now();
    return {st_memr, st_m1, st_inp, st_out, ~st_wo_n, st_inta};
  endfunction

  task automatic chk_idle(input string tag);
    chk(req_ready && !psync && pstval_n && !pdbin && pwr_n && !mwrt && !rsp_valid,
        tag, {req_ready, psync, pstval_n, pdbin, pwr_n, mwrt, rsp_valid}, 7'b1010100);
    chk(st_now() == 6'b0, tag, st_now(), 0);
  endtask

  task automatic run_vec(input logic [VW-1:0] v);
    logic [2:0] k;  logic [AW-1:0] a;  logic [DW-1:0] wd, dn;
    logic [3:0] nw; logic [5:0] es;  logic rd, wr, mw;
    {k, a, wd, dn, nw, es} = v;
    rd = es[5] | es[3] | es[0];
    wr = es[1];
    mw = es[1] & ~es[2];
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    @(negedge clk);  // sync phase
    chk(psync && !pstval_n && !req_ready, "R2 sync phase", {psync, pstval_n, req_ready}, 3'b100);
    chk(st_now() == es, "R3 status", st_now(), es);
    chk(bus_addr == a, "R9 address", bus_addr, a);
    req_valid = 1'b0;
    if (nw == 0) begin bus_rdy = 1'b1; bus_din = dn; end
    else begin bus_rdy = 1'b0; bus_din = ~dn; end
    @(negedge clk);  // strobe phase
    chk(!psync && pstval_n, "R2 sync one clock", {psync, pstval_n}, 2'b01);
    chk(pdbin == rd, "R4 read strobe", pdbin, rd);
    chk(pwr_n == !wr, "R5 write strobe", pwr_n, !wr);
    chk(mwrt == mw, "R8 memory write strobe", mwrt, mw);
    if (wr) chk(bus_dout == wd, "R5 data out", bus_dout, wd);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      chk(pdbin == rd && pwr_n == !wr && !rsp_valid, "R6 wait extends",
          {pdbin, pwr_n, rsp_valid}, {rd, !wr, 1'b0});
      if (w == nw - 1) begin bus_rdy = 1'b1; bus_din = dn; end
    end
    @(negedge clk);  // release phase
    chk(!pdbin && pwr_n && !mwrt, "R6 release", {pdbin, pwr_n, mwrt}, 3'b010);
    chk(rsp_valid == rd, "R7 response valid", rsp_valid, rd);
    if (rd) chk(rsp_data == dn, "R7 read data", rsp_data, dn);
    chk(bus_addr == a && st_now() == es, "R9 held in release", bus_addr, a);
    @(negedge clk);
    chk_idle("R1 back to idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset");

    for (int i = 0; i < 8; i++) run_vec(VEC[i]);

    // R10: request held through a whole cycle is taken only from idle.
    req_valid = 1'b1; req_kind = 3'd0; req_addr = 24'h00AAAA; bus_rdy = 1'b1;
    @(negedge clk);
    req_addr = 24'h00BBBB; req_kind = 3'd2;
    @(negedge clk);
    chk(bus_addr == 24'h00AAAA && st_memr && !st_inp, "R10 busy ignores request",
        bus_addr, 24'h00AAAA);
    @(negedge clk);
    chk(bus_addr == 24'h00AAAA && !req_ready, "R10 release ignores request",
        bus_addr, 24'h00AAAA);
    @(negedge clk);
    chk(req_ready && !psync, "R10 idle one clock", {req_ready, psync}, 2'b10);
    @(negedge clk);
    chk(psync && bus_addr == 24'h00BBBB && st_inp, "R10 next request starts",
        bus_addr, 24'h00BBBB);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 idle after held request");

    // R1: reset in the middle of a stretched strobe phase.
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 24'h000777; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0; bus_rdy = 1'b0;
    @(negedge clk);
    chk(!pwr_n && mwrt, "R8 memory write during wait", {pwr_n, mwrt}, 2'b01);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset mid-cycle");
    @(negedge clk);
    rst_n = 1'b1; bus_rdy = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after mid-cycle reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule